// File: doc/BRIEF.md
# Programmable ROM Mode Controller

This block is a synthesizable behavioural model of a 16-bit-wide, one-time-programmable memory together with the decode of its control pins. An address, an active-low chip select, an active-low output gate, a parallel input word and two logic flags drive it. One flag stands in for the high programming supply. The other stands in for the raised identifier level on address bit 9. From these inputs the block selects one of seven modes: read, output disable, standby, program, verify, program inhibit and signature readout. It drives a 16-bit output word together with an enable that a pad ring would use for the tri-state pins.

The array lives in registers and its depth is a parameter. Every word starts at all ones. A program operation can only clear bits. The write happens once, on the rising edge of the chip-select pulse, which is sampled on the system clock. The output word and its enable pass through a parameterised number of register stages that model access latency. Analog levels, erase and supply sequencing are not modelled.

Top module: `otpRomCtrl`

## Requirements
- R1: After reset every array word reads 0xFFFF, and dataOutEn is low with dataOut equal to 0x0000.
- R2: While ceN is high, dataOutEn is low whatever the levels of oeN, progVolt and idVolt (standby and program inhibit).
- R3: With ceN low, oeN low, progVolt low and idVolt low, the output carries the stored word at addr and dataOutEn is high (read).
- R4: With ceN low, oeN high and progVolt low, dataOutEn is low (output disable).
- R5: A program operation replaces the stored word with the old word ANDed with the applied data, so no bit ever returns from 0 to 1.
- R6: A cycle with progVolt high, ceN low and oeN high is a program cycle. The first cycle with ceN high after a program cycle commits exactly one write, whatever progVolt is in that cycle. The write uses the addr and dataIn of the last program cycle. A pulse that ends through oeN going low commits nothing.
- R7: Whenever dataOutEn is low, dataOut is 0x0000.
- R8: With progVolt high and both ceN and oeN low, the output carries the stored word at addr whatever idVolt is (verify, where programming takes priority over signature).
- R9: With idVolt high, progVolt low and both ceN and oeN low, the output carries 0x0020 when addr bit 0 is 0 and 0x008D when addr bit 0 is 1 (signature, zero-extended to 16 bits).
- R10: dataOut and dataOutEn reflect the inputs sampled LAT rising clock edges earlier. With LAT=2, a read driven before edge n shows dataOutEn low after edge n and high after edge n+1.
- R11: Holding progVolt high with ceN high over any number of cycles writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output gate |
| progVolt | input | 1 | Programming supply present |
| idVolt | input | 1 | Identifier level present on address bit 9 |
| dataIn | input | 16 | Word to program |
| dataOut | output | 16 | Output word |
| dataOutEn | output | 1 | Output driver enable |

## Verification
The hardest case to reach is the end of a program pulse. The write depends on what the pins did in the previous cycle, not the current one. So the stimulus holds chip select low over several cycles and changes the data in the middle of the pulse. It ends one pulse through the output gate instead of chip select, and raises chip select with the programming flag already dropped. Repeated programs of one address with overlapping patterns, followed by read-back, show that bits only clear. A behavioural model, run on every clock, follows the latency pipeline through each mode change.

// File: rtl/otpRomPkg.sv
package otpRomPkg;
  localparam int WORD_W = 16;
  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'h8D;

  typedef struct packed {
    logic drive;    // output word valid this cycle
    logic selSig;   // pick identifier code instead of array word
    logic capture;  // latch address/data of a program cycle
    logic writeEn;  // commit latched word into array
  } romStrobe_t;
endpackage

// File: rtl/otpRomDecode.sv
module otpRomDecode
  import otpRomPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       progVolt,
  input  logic       idVolt,
  output romStrobe_t stb
);
  logic progCycle;
  logic prevProg;

  assign progCycle = progVolt & ~ceN & oeN;

  always_ff @(posedge clk) begin
    if (!rstN) prevProg <= 1'b0;
    else       prevProg <= progCycle;
  end

  always_comb begin
    stb = '0;
    stb.capture = progCycle;
    stb.writeEn = prevProg & ceN;
    if (!ceN && !oeN) begin
      stb.drive  = 1'b1;
      stb.selSig = idVolt & ~progVolt;
    end
  end
endmodule

// File: rtl/otpRomDatapath.sv
module otpRomDatapath
  import otpRomPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  input  romStrobe_t        stb,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] pendData;
  logic [WORD_W-1:0] sigWord;
  logic [WORD_W-1:0] stageWord;
  logic [WORD_W:0]   pipe [LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '1;
    end else if (stb.capture) begin
      pendAddr <= addr;
      pendData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.writeEn) begin
      mem[pendAddr] <= mem[pendAddr] & pendData;
    end
  end

  assign sigWord   = {{(WORD_W-8){1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};
  assign stageWord = !stb.drive ? '0 : (stb.selSig ? sigWord : mem[addr]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {stb.drive, stageWord};
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dataOutEn = pipe[LAT-1][WORD_W];
  assign dataOut   = pipe[LAT-1][WORD_W-1:0];
endmodule

// File: rtl/otpRomCtrl.sv
module otpRomCtrl
  import otpRomPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progVolt,
  input  logic              idVolt,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              dataOutEn
);
  romStrobe_t stb;

  otpRomDecode decode_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN),
    .progVolt(progVolt), .idVolt(idVolt), .stb(stb)
  );

  otpRomDatapath #(.ADDR_W(ADDR_W), .LAT(LAT)) datapath_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .stb(stb),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/otpRomCtrl_chk.sv
module otpRomCtrl_chk
  import otpRomPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        ceN,
  input logic        oeN,
  input logic        progVolt,
  input logic [15:0] dataOut,
  input logic        dataOutEn,
  input romStrobe_t  stb
);
  p_standby_no_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !stb.drive);

  p_disable_no_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |-> !stb.drive);

  p_single_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |=> !stb.writeEn);

  p_write_on_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |-> (ceN && $past(!ceN)));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == 16'h0000));

  p_sig_suppressed_r8: assert property (@(posedge clk) disable iff (!rstN)
    progVolt |-> !stb.selSig);
endmodule

bind otpRomCtrl otpRomCtrl_chk chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .progVolt(progVolt),
  .dataOut(dataOut), .dataOutEn(dataOutEn), .stb(stb)
);

// File: tb/otpRomCtrl_tb_top.sv
`timescale 1ns/1ps
module otpRomCtrl_tb_top;
  localparam int ADDR_W = 6;
  localparam int LAT    = 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic ceN = 1'b1, oeN = 1'b1, progVolt = 1'b0, idVolt = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic dataOutEn;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  otpRomCtrl #(.ADDR_W(ADDR_W), .LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN),
    .progVolt(progVolt), .idVolt(idVolt), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // behavioural reference model
  logic [15:0] mMem [DEPTH];
  logic [16:0] hist [$];
  bit          mPrev;
  int          mPa;
  logic [15:0] mPd;

  always @(posedge clk) begin
    logic [16:0] expV;
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mMem[i] = 16'hFFFF;
      hist.delete();
      for (int i = 0; i < LAT; i++) hist.push_front(17'h0);
      mPrev = 1'b0;
    end else begin
      if (ceN)                 expV = 17'h0;
      else if (oeN)            expV = 17'h0;
      else if (progVolt)       expV = {1'b1, mMem[addr]};
      else if (idVolt)         expV = {1'b1, (addr[0] ? 16'h008D : 16'h0020)};
      else                     expV = {1'b1, mMem[addr]};
      hist.push_front(expV);
      if (hist.size() > LAT) void'(hist.pop_back());
      if (mPrev && ceN) mMem[mPa] = mMem[mPa] & mPd;
      mPrev = progVolt && !ceN && oeN;
      if (mPrev) begin
        mPa = int'(addr);
        mPd = dataIn;
      end
    end
    #1;
    checks++;
    if ({dataOutEn, dataOut} !== hist[LAT-1]) begin
      errors++;
      $display("FAIL %s (R7/R10 model) en/data got %b/%h expected %b/%h",
               curReq, dataOutEn, dataOut, hist[LAT-1][16], hist[LAT-1][15:0]);
    end
  end

  task automatic setIn(input logic c, input logic o, input logic pv,
                       input logic id, input int a, input logic [15:0] d);
    @(negedge clk);
    ceN = c; oeN = o; progVolt = pv; idVolt = id;
    addr = ADDR_W'(a); dataIn = d;
  endtask

  task automatic expectOut(input string req, input logic en, input logic [15:0] d);
    checks++;
    if (dataOutEn !== en || dataOut !== d) begin
      errors++;
      $display("FAIL %s got en=%b data=%h expected en=%b data=%h",
               req, dataOutEn, dataOut, en, d);
    end
  endtask

  task automatic readWord(input string req, input int a, input logic [15:0] d);
    setIn(1'b0, 1'b0, 1'b0, 1'b0, a, 16'h0);
    repeat (LAT) @(posedge clk);
    #1.5;
    expectOut(req, 1'b1, d);
  endtask

  task automatic programWord(input int a, input logic [15:0] d, input int len);
    for (int i = 0; i < len; i++) setIn(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    setIn(1'b1, 1'b1, 1'b1, 1'b0, a, d);
    setIn(1'b1, 1'b1, 1'b0, 1'b0, a, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0.5; expectOut("R1", 1'b0, 16'h0000);
    curReq = "R1"; readWord("R1", 5, 16'hFFFF); readWord("R1", DEPTH-1, 16'hFFFF);

    curReq = "R2";
    for (int i = 0; i < 4; i++) setIn(1'b1, 1'b0, 1'b0, i[0], i, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R2", 1'b0, 16'h0000);

    curReq = "R4";
    setIn(1'b0, 1'b1, 1'b0, 1'b0, 2, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R4", 1'b0, 16'h0000);

    curReq = "R10";
    setIn(1'b1, 1'b1, 1'b0, 1'b0, 0, 16'h0);
    repeat (LAT) @(posedge clk);
    setIn(1'b0, 1'b0, 1'b0, 1'b0, 4, 16'h0);
    @(posedge clk); #1.5; expectOut("R10", 1'b0, 16'h0000);
    @(posedge clk); #1.5; expectOut("R10", 1'b1, 16'hFFFF);

    curReq = "R5";
    programWord(3, 16'h0F0F, 2); readWord("R5", 3, 16'h0F0F);
    programWord(3, 16'hFF00, 1); readWord("R5", 3, 16'h0F00);
    programWord(3, 16'hFFFF, 3); readWord("R5", 3, 16'h0F00);
    readWord("R3", 4, 16'hFFFF);

    curReq = "R6";
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 10, 16'h0000);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 10, 16'h1234);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 11, 16'hAAAA);
    setIn(1'b1, 1'b1, 1'b0, 1'b0, 11, 16'h0000);
    readWord("R6", 11, 16'hAAAA); readWord("R6", 10, 16'hFFFF);
    setIn(1'b0, 1'b1, 1'b1, 1'b0, 12, 16'h0000);
    setIn(1'b0, 1'b0, 1'b1, 1'b0, 12, 16'h0000);
    setIn(1'b1, 1'b1, 1'b1, 1'b0, 12, 16'h0000);
    readWord("R6", 12, 16'hFFFF);

    curReq = "R8";
    setIn(1'b0, 1'b0, 1'b1, 1'b1, 3, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R8", 1'b1, 16'h0F00);
    setIn(1'b0, 1'b0, 1'b1, 1'b1, 1, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R8", 1'b1, 16'hFFFF);

    curReq = "R11";
    for (int i = 0; i < 5; i++) setIn(1'b1, i[0], 1'b1, 1'b0, 7, 16'h0000);
    setIn(1'b1, 1'b1, 1'b0, 1'b0, 7, 16'h0);
    readWord("R11", 7, 16'hFFFF);

    curReq = "R9";
    setIn(1'b0, 1'b0, 1'b0, 1'b1, 0, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R9", 1'b1, 16'h0020);
    setIn(1'b0, 1'b0, 1'b0, 1'b1, 33, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R9", 1'b1, 16'h008D);
    setIn(1'b0, 1'b1, 1'b0, 1'b1, 33, 16'h0);
    repeat (LAT) @(posedge clk); #1.5; expectOut("R4", 1'b0, 16'h0000);

    curReq = "R3";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        programWord(int'(lfsr[5:0]), lfsr ^ 16'h5A5A, 1 + (i % 3));
        setIn(1'b0, 1'b0, 1'b0, lfsr[7], int'(lfsr[11:6]), 16'h0);
        setIn(lfsr[8], lfsr[9], lfsr[10], 1'b0, int'(lfsr[5:0]), 16'h0);
      end
    end
    repeat (LAT + 2) @(posedge clk);
    done = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule